// File: doc/BRIEF.md
# XOR Fault Rectification Unit

This block fixes the logic value of one faulty output line by pure state correction; it never tries to locate where the fault sits. A small correction function is stored as a lookup table. Each of its address bits comes from a per-input selector, which can pick any line of a bus of global node signals. That line does not have to be an input of the broken module. The corrected line is the faulty line XORed with the table output. For the fix to work, the table must hold 1 for exactly those input states in which the broken module is wrong.

A configuration port loads two things: the select code and enable of each table input, and the whole table word. Those contents are worked out off-block. Simple correction shapes map onto table patterns: a node used directly, a node inverted, or the AND or OR of two nodes. The correction path has no register in it. Only the configuration is stored.

Top module: `rect_unit`

## Requirements
- R1: `correctedOut` always equals `faultyBit` XOR table entry `tbl[idx]`, where `idx` is the 5-bit index formed from the selected inputs.
- R2: After reset every input is disabled and the table is all zeros, so `correctedOut` equals `faultyBit`.
- R3: Index bit k comes from table input k. Input 0 is the least significant bit of `idx`.
- R4: A disabled table input contributes 0 to the index, whatever the value of the node it selects.
- R5: The select code of an input picks `nodeBus[code]`, and any line from 0 to NODE_W-1 can be chosen.
- R6: A configuration write takes effect at the first rising clock edge at which `cfgWe` is high. The table and the selects do not change while `cfgWe` is low.
- R7: A write with `cfgAddr` equal to k (0..4) sets input k: `cfgData[3:0]` is the node code and `cfgData[4]` is the enable. A write with `cfgAddr` equal to 5 loads all 32 table entries from `cfgData`, with bit i holding entry i.
- R8: A write to an address above 5 changes neither the selects nor the table.
- R9: `correctedOut` follows changes on `nodeBus` and `faultyBit` within the same cycle, with no clock edge needed.
- R10: The table patterns for direct, inverted, AND and OR correction give the matching corrected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 3 | Configuration target: 0..4 input selects, 5 table |
| cfgData | input | 32 | Configuration write data |
| nodeBus | input | NODE_W (16) | Global node signals available to the table inputs |
| faultyBit | input | 1 | Output of the faulty module |
| correctedOut | output | 1 | Repaired output |

## Verification
The checker watches the decoded write strobes on every cycle. At most one strobe is active at a time, and none is active when the port is idle or the address is out of range. It also checks, cycle by cycle, that the output follows the table bit through the XOR and stays stable when neither the inputs nor the configuration have changed. Only the bench scenarios can show the rest: the index bit order, the masking by the enable bits, the reach of the select codes up to the top node, the cycle in which a write takes effect, and the direct, inverted, AND and OR patterns. Each of these needs a known configuration to compare against.

// File: rtl/rect_pkg.sv
package rect_pkg;
  localparam int RECT_IN = 5;                 // table inputs
  localparam int TBL_N   = 1 << RECT_IN;      // table entries
  localparam int ADDR_W  = $clog2(RECT_IN + 1);
  localparam int DATA_W  = TBL_N;

  typedef struct packed {
    logic [RECT_IN-1:0] selWe;   // one strobe per input select register
    logic               tblWe;   // table word load
  } rect_strobe_t;
endpackage

// File: rtl/rect_ctrl.sv
module rect_ctrl
  import rect_pkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output rect_strobe_t      strobe
);
  localparam logic [ADDR_W-1:0] TBL_ADDR = ADDR_W'(RECT_IN);

  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      for (int k = 0; k < RECT_IN; k++) begin
        if (cfgAddr == ADDR_W'(k)) strobe.selWe[k] = 1'b1;
      end
      if (cfgAddr == TBL_ADDR) strobe.tblWe = 1'b1;
    end
  end
endmodule

// File: rtl/rect_datapath.sv
module rect_datapath
  import rect_pkg::*;
#(
  parameter int NODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rect_strobe_t      strobe,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [NODE_W-1:0] nodeBus,
  input  logic              faultyBit,
  output logic              rectBit,
  output logic              correctedOut
);
  localparam int SEL_W = $clog2(NODE_W);

  logic [SEL_W-1:0]   selIdx [RECT_IN];
  logic [RECT_IN-1:0] selEn;
  logic [TBL_N-1:0]   tbl;
  logic [RECT_IN-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < RECT_IN; k++) selIdx[k] <= '0;
      selEn <= '0;
      tbl   <= '0;
    end else begin
      for (int k = 0; k < RECT_IN; k++) begin
        if (strobe.selWe[k]) begin
          selIdx[k] <= cfgData[SEL_W-1:0];
          selEn[k]  <= cfgData[SEL_W];
        end
      end
      if (strobe.tblWe) tbl <= cfgData[TBL_N-1:0];
    end
  end

  for (genvar k = 0; k < RECT_IN; k++) begin : g_pick
    assign idx[k] = selEn[k] & nodeBus[selIdx[k]];
  end

  assign rectBit      = tbl[idx];
  assign correctedOut = faultyBit ^ rectBit;
endmodule

// File: rtl/rect_unit.sv
module rect_unit
  import rect_pkg::*;
#(
  parameter int NODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [NODE_W-1:0] nodeBus,
  input  logic              faultyBit,
  output logic              correctedOut
);
  rect_strobe_t strobe;
  logic         rectBit;

  rect_ctrl u_ctrl (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .strobe (strobe)
  );

  rect_datapath #(.NODE_W(NODE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgData     (cfgData),
    .nodeBus     (nodeBus),
    .faultyBit   (faultyBit),
    .rectBit     (rectBit),
    .correctedOut(correctedOut)
  );
endmodule

// File: rtl/rect_unit_chk.sv
module rect_unit_chk
  import rect_pkg::*;
#(
  parameter int NODE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [NODE_W-1:0] nodeBus,
  input logic              faultyBit,
  input logic              correctedOut,
  input rect_strobe_t      strobe,
  input logic              rectBit
);
  localparam logic [ADDR_W-1:0] TBL_ADDR = ADDR_W'(RECT_IN);

  // R1: a zero table bit leaves the faulty line untouched, a one flips it
  a_r1_xor_pass: assert property (@(posedge clk) disable iff (!rstN)
    !rectBit |-> (correctedOut == faultyBit));
  a_r1_xor_flip: assert property (@(posedge clk) disable iff (!rstN)
    rectBit |-> (correctedOut != faultyBit));

  // R7: at most one target written per cycle
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWe, strobe.tblWe}));

  // R6: no strobe while the port is idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |-> (strobe == '0));

  // R8: out-of-range address yields no strobe
  a_r8_bad_addr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr > TBL_ADDR) |-> (strobe == '0));

  // R6 and R9: with no write and unchanged inputs the output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgWe) && $stable(nodeBus) && $stable(faultyBit)) |-> $stable(correctedOut));
endmodule

bind rect_unit rect_unit_chk #(.NODE_W(NODE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .cfgAddr     (cfgAddr),
  .nodeBus     (nodeBus),
  .faultyBit   (faultyBit),
  .correctedOut(correctedOut),
  .strobe      (strobe),
  .rectBit     (rectBit)
);

// File: tb/sim_rect_unit.sv
module sim_rect_unit;
  localparam int NODE_W = 16;
  localparam int NIN    = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [NODE_W-1:0] nodeBus = '0;
  logic        faultyBit = 1'b0;
  logic        correctedOut;

  int checks = 0;
  int errors = 0;

  // bench model of the configuration, kept from the requirements
  logic [3:0]  mSel [NIN];
  logic [NIN-1:0] mEn = '0;
  logic [31:0] mTbl = '0;

  always #2 clk = ~clk;   // 250 MHz

  rect_unit #(.NODE_W(NODE_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .nodeBus(nodeBus), .faultyBit(faultyBit), .correctedOut(correctedOut)
  );

  function automatic logic expOut();
    logic [NIN-1:0] ix;
    for (int k = 0; k < NIN; k++) ix[k] = mEn[k] & nodeBus[mSel[k]];
    return faultyBit ^ mTbl[ix];
  endfunction

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (correctedOut !== exp) begin
      errors++;
      $display("FAIL %s node=%h faulty=%b actual=%b expected=%b",
               tag, nodeBus, faultyBit, correctedOut, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    if (a < 3'(NIN)) begin mSel[a] = d[3:0]; mEn[a] = d[4]; end
    else if (a == 3'(NIN)) mTbl = d;
  endtask

  task automatic drive(input logic [NODE_W-1:0] n, input logic f);
    nodeBus = n; faultyBit = f; #1;
  endtask

  task automatic clearCfg();
    for (int k = 0; k < NIN; k++) wr(3'(k), 32'h0);
    wr(3'(NIN), 32'h0);
  endtask

  task automatic t_reset();   // R2
    logic [NODE_W-1:0] pat [4] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234};
    for (int i = 0; i < 4; i++) begin
      drive(pat[i], 1'b0); chk("R2 reset pass", 1'b0);
      drive(pat[i], 1'b1); chk("R2 reset pass", 1'b1);
    end
  endtask

  task automatic t_shapes();  // R10, R1
    clearCfg();
    wr(3'd0, 32'h13);           // input0 <- node3, enabled
    wr(3'd5, 32'hAAAA_AAAA);    // direct
    for (int i = 0; i < 4; i++) begin
      drive(16'(i[1] << 3), i[0]);
      chk("R10 direct", i[0] ^ i[1]);
    end
    wr(3'd5, 32'h5555_5555);    // inverted
    for (int i = 0; i < 4; i++) begin
      drive(16'(i[1] << 3), i[0]);
      chk("R10 invert", i[0] ^ ~i[1]);
    end
    wr(3'd1, 32'h17);           // input1 <- node7
    wr(3'd5, 32'h0000_0008);    // AND: entry 3
    for (int i = 0; i < 4; i++) begin
      drive(16'((i[0] << 3) | (i[1] << 7)), 1'b0);
      chk("R10 and", i[0] & i[1]);
    end
    wr(3'd5, 32'h0000_000E);    // OR: entries 1..3
    for (int i = 0; i < 4; i++) begin
      drive(16'((i[0] << 3) | (i[1] << 7)), 1'b1);
      chk("R1 or xor", 1'b1 ^ (i[0] | i[1]));
    end
  endtask

  task automatic t_order();   // R3
    clearCfg();
    for (int k = 0; k < NIN; k++) wr(3'(k), 32'(16 + k));  // input k <- node k
    for (int k = 0; k < NIN; k++) begin
      wr(3'd5, 32'(1) << (1 << k));   // only entry with bit k set alone
      drive(16'(1 << k), 1'b0);  chk("R3 bit order hit", 1'b1);
      drive(16'(1 << ((k + 1) % NIN)), 1'b0); chk("R3 bit order miss", 1'b0);
      drive(16'(1 << k), 1'b0);  chk("R3 model", expOut());
    end
  endtask

  task automatic t_disable(); // R4
    clearCfg();
    wr(3'd2, 32'h05);             // input2 <- node5, disabled
    wr(3'd5, 32'hFFFF_FFFE);      // all entries 1 except entry 0
    drive(16'hFFFF, 1'b0); chk("R4 disabled masked", 1'b0);
    wr(3'd2, 32'h15);             // now enabled
    drive(16'hFFFF, 1'b0); chk("R4 enabled counts", 1'b1);
  endtask

  task automatic t_topNode(); // R5
    clearCfg();
    wr(3'd4, 32'h1F);             // input4 <- node15
    wr(3'd5, 32'h0001_0000);      // entry 16
    drive(16'h8000, 1'b0); chk("R5 top node", 1'b1);
    drive(16'h7FFF, 1'b0); chk("R5 top node low", 1'b0);
  endtask

  task automatic t_timing();  // R6, R8, R7
    clearCfg();
    wr(3'd0, 32'h10);             // input0 <- node0
    drive(16'h0001, 1'b0);
    @(negedge clk);
    cfgAddr = 3'd5; cfgData = 32'h2; cfgWe = 1'b0;
    @(posedge clk); #1;
    chk("R6 idle no write", 1'b0);
    @(negedge clk);
    cfgWe = 1'b1; #1;
    chk("R6 before edge", 1'b0);
    @(posedge clk); #1;
    cfgWe = 1'b0; mTbl = 32'h2;
    chk("R6 after edge", 1'b1);
    wr(3'd7, 32'h0);              // bad address
    wr(3'd6, 32'h0);
    chk("R8 bad addr ignored", 1'b1);
    wr(3'd5, 32'hFFFF_FFFD);
    chk("R7 table whole word", 1'b0);
  endtask

  task automatic t_comb();    // R9
    clearCfg();
    wr(3'd0, 32'h19);             // input0 <- node9
    wr(3'd5, 32'h2);
    @(posedge clk); #1;           // mid-cycle
    drive(16'h0200, 1'b0); chk("R9 node mid cycle", 1'b1);
    drive(16'h0200, 1'b1); chk("R9 faulty mid cycle", 1'b0);
    drive(16'h0000, 1'b1); chk("R9 node drop", 1'b1);
  endtask

  initial begin
    for (int k = 0; k < NIN; k++) mSel[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_shapes();
    t_order();
    t_disable();
    t_topNode();
    t_timing();
    t_comb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule